// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Loader

This block is the digital front end of a two-channel 12-bit converter. A host writes it over an 8-bit parallel bus that has an active-low select and an active-low write strobe. A 2-bit address picks one of four staging registers: the low byte and the high nibble of each channel. The host may fill the staging registers in any order, and the analog side sees none of those writes until the load input is driven low. One shared active-low load strobe then copies both staged 12-bit words into the output code registers at the same time.

Every pin input first passes through a two-flop synchronizer. All later decisions are made in the single clock domain. A write commits in the clock in which the synchronized select-and-write combination ends. The address and data used are the ones sampled while that combination was active. While the synchronized load is low, the outputs follow the staging registers, including a value committed in that same clock. When load rises, the outputs keep the value they have at that point. A write that ends no later than the load's rising edge is always included in the captured value.

Top module: `dac_dual_loader`

## Requirements
- R1: After synchronous reset, both output codes and all four staging registers read zero. A load issued straight after reset drives both outputs to 0x000.
- R2: Address 2'b00 writes channel A bits [7:0] from the bus. Address 2'b01 writes channel A bits [11:8] from bus bits [3:0]. Address 2'b10 and 2'b11 do the same for channel B. For a high-nibble write, bus bits [7:4] are ignored.
- R3: A staging register changes only when select and write are both low. A write strobe given while select is high changes nothing, and so does a select given while the write strobe is high.
- R4: The staging registers can be written in any order. While load is high, no write changes either output code.
- R5: While load is low, both output codes follow their staging registers. After load rises, the outputs hold their value until the next load.
- R6: A load pulse with no write activity copies both staged words into the outputs at the same time.
- R7: If a load pulse overlaps a write, and the write ends no later than the load rises, the captured outputs contain the newly written value.
- R8: A write uses the data present while the strobe was active. A bus value that appears as the strobe ends is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| load_n | input | 1 | Active-low load strobe; transfers the staged words to both outputs |
| addr | input | 2 | Staging register select |
| data | input | 8 | Right-justified write data |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
The bench writes the high byte before the low byte on one channel, and checks that neither output moves before a load. A design that forwarded writes directly to the outputs would show partial codes at that point. It gives strobes with only select or only write asserted; a decoder that tests a single strobe would corrupt a staging register. It changes the bus in the same clock the strobe ends, which exposes a design that samples data at the commit edge instead of during the strobe. It releases load in the same cycle as a write ends, and holds load low across a write. A design without forwarding, or one that closes the output register one clock early, would capture the stale code in those cases.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

    localparam int BUS_W  = 8;
    localparam int CODE_W = 12;
    localparam int HI_W   = CODE_W - BUS_W;
    localparam int ADDR_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_A_LO = 2'b00,
        SLOT_A_HI = 2'b01,
        SLOT_B_LO = 2'b10,
        SLOT_B_HI = 2'b11
    } slot_e;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [BUS_W-1:0] lo;
    } code_t;

    typedef struct packed {
        logic              sel_n;
        logic              wr_n;
        logic              load_n;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, load_n: 1'b1,
                                    addr: '0, data: '0};

    function automatic code_t put_slot(input code_t cur, input logic is_hi,
                                       input logic [BUS_W-1:0] d);
        code_t r;
        r = cur;
        if (is_hi) r.hi = d[HI_W-1:0];
        else       r.lo = d;
        return r;
    endfunction

endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
    parameter int               W       = 1,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/dacl_stage.sv
module dacl_stage
    import dacl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output code_t stg_a,
    output code_t stg_b,
    output code_t nxt_a,
    output code_t nxt_b,
    output logic  commit
);
    logic             strobe_on;
    logic             strobe_d;
    slot_e            hold_slot;
    logic [BUS_W-1:0] hold_data;

    assign strobe_on = ~pins.sel_n & ~pins.wr_n;
    assign commit    = strobe_d & ~strobe_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d  <= 1'b0;
            hold_slot <= SLOT_A_LO;
            hold_data <= '0;
        end else begin
            strobe_d <= strobe_on;
            if (strobe_on) begin
                hold_slot <= slot_e'(pins.addr);
                hold_data <= pins.data;
            end
        end
    end

    always_comb begin
        nxt_a = stg_a;
        nxt_b = stg_b;
        if (commit) begin
            unique case (hold_slot)
                SLOT_A_LO: nxt_a = put_slot(stg_a, 1'b0, hold_data);
                SLOT_A_HI: nxt_a = put_slot(stg_a, 1'b1, hold_data);
                SLOT_B_LO: nxt_b = put_slot(stg_b, 1'b0, hold_data);
                SLOT_B_HI: nxt_b = put_slot(stg_b, 1'b1, hold_data);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_a <= '0;
            stg_b <= '0;
        end else begin
            stg_a <= nxt_a;
            stg_b <= nxt_b;
        end
    end

    // R3: without a completed select-and-write strobe nothing is staged
    assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
        !strobe_d |=> ($stable(stg_a) && $stable(stg_b)));

    // R2: low-byte slot of channel A takes the held byte
    assert_slot_a_lo_R2: assert property (@(posedge clk) disable iff (rst)
        (strobe_d && !strobe_on && hold_slot == SLOT_A_LO)
            |=> (stg_a.lo == $past(hold_data) && $stable(stg_b)));

    // R2: high-nibble slot of channel B takes the low bus bits
    assert_slot_b_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (strobe_d && !strobe_on && hold_slot == SLOT_B_HI)
            |=> (stg_b.hi == $past(hold_data[HI_W-1:0]) && $stable(stg_a)));

endmodule

// File: rtl/dacl_out.sv
module dacl_out
    import dacl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_n_s,
    input  logic  commit,
    input  code_t nxt_a,
    input  code_t nxt_b,
    input  code_t stg_a,
    input  code_t stg_b,
    output code_t out_a,
    output code_t out_b
);
    logic load_n_d;
    logic take;

    // transparent while low; one extra clock when load rises on a commit
    assign take = ~load_n_s | (~load_n_d & commit);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_n_d <= 1'b1;
            out_a    <= '0;
            out_b    <= '0;
        end else begin
            load_n_d <= load_n_s;
            if (take) begin
                out_a <= nxt_a;
                out_b <= nxt_b;
            end
        end
    end

    // R4: outputs frozen while load stays high
    assert_hold_while_high_R4: assert property (@(posedge clk) disable iff (rst)
        (load_n_s && load_n_d) |=> ($stable(out_a) && $stable(out_b)));

    // R5: outputs track staging while load is low
    assert_follow_while_low_R5: assert property (@(posedge clk) disable iff (rst)
        !load_n_s |=> (out_a == stg_a && out_b == stg_b));

    // R7: a write ending as load rises is captured
    assert_overlap_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (load_n_s && !load_n_d && commit) |=> (out_a == stg_a && out_b == stg_b));

    // R1: reset clears both codes
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (out_a == '0 && out_b == '0));

endmodule

// File: rtl/dac_dual_loader.sv
module dac_dual_loader
    import dacl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  data,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    pins_t raw_pins;
    pins_t syn_pins;
    code_t stg_a, stg_b, nxt_a, nxt_b, out_a, out_b;
    logic  commit;

    assign raw_pins = '{sel_n: sel_n, wr_n: wr_n, load_n: load_n,
                        addr: addr, data: data};

    dacl_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    dacl_stage stage_i (
        .clk    (clk),
        .rst    (rst),
        .pins   (syn_pins),
        .stg_a  (stg_a),
        .stg_b  (stg_b),
        .nxt_a  (nxt_a),
        .nxt_b  (nxt_b),
        .commit (commit)
    );

    dacl_out out_i (
        .clk      (clk),
        .rst      (rst),
        .load_n_s (syn_pins.load_n),
        .commit   (commit),
        .nxt_a    (nxt_a),
        .nxt_b    (nxt_b),
        .stg_a    (stg_a),
        .stg_b    (stg_b),
        .out_a    (out_a),
        .out_b    (out_b)
    );

    assign code_a = out_a;
    assign code_b = out_b;

endmodule

// File: tb/dac_dual_loader_tb_top.sv
module dac_dual_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        load_n = 1'b1;
    logic [1:0]  addr = 2'b00;
    logic [7:0]  data = 8'h00;
    logic [11:0] code_a, code_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [11:0] a;
        logic [11:0] b;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    dac_dual_loader dut_i (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .wr_n   (wr_n),
        .load_n (load_n),
        .addr   (addr),
        .data   (data),
        .code_a (code_a),
        .code_b (code_b)
    );

    // monitor: pops expectations and compares at the falling edge
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            @(negedge clk);
            checks++;
            if (code_a !== exp_q[0].a || code_b !== exp_q[0].b) begin
                fails++;
                $display("FAIL %s: a=%h b=%h expected a=%h b=%h",
                         exp_q[0].tag, code_a, code_b, exp_q[0].a, exp_q[0].b);
            end
            void'(exp_q.pop_front());
        end
    end

    task automatic expect_codes(input logic [11:0] a, input logic [11:0] b,
                                input string tag);
        exp_t e;
        e.a = a; e.b = b; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                             input logic use_sel, input logic use_wr);
        @(negedge clk);
        addr = a; data = d;
        sel_n = ~use_sel; wr_n = ~use_wr;
        idle(3);
        sel_n = 1'b1; wr_n = 1'b1;
        idle(5);
    endtask

    task automatic pulse_load;
        @(negedge clk);
        load_n = 1'b0;
        idle(3);
        load_n = 1'b1;
        idle(5);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        expect_codes(12'h000, 12'h000, "R1 reset state");

        bus_write(2'b00, 8'h34, 1, 1);
        bus_write(2'b01, 8'hF2, 1, 1);
        expect_codes(12'h000, 12'h000, "R4 channel A staged, load high");
        bus_write(2'b11, 8'h07, 1, 1);
        bus_write(2'b10, 8'hAB, 1, 1);
        expect_codes(12'h000, 12'h000, "R4 channel B high-first order, load high");

        pulse_load();
        expect_codes(12'h234, 12'h7AB, "R2 R6 load transfers both channels");

        bus_write(2'b00, 8'h99, 1, 1);
        expect_codes(12'h234, 12'h7AB, "R5 R4 held after load rises");

        bus_write(2'b01, 8'h05, 0, 1);
        pulse_load();
        expect_codes(12'h299, 12'h7AB, "R3 write with select high ignored");

        bus_write(2'b10, 8'h00, 1, 0);
        pulse_load();
        expect_codes(12'h299, 12'h7AB, "R3 select without write ignored");

        // R8: bus changes in the same cycle the strobe ends
        @(negedge clk);
        addr = 2'b01; data = 8'h0C; sel_n = 1'b0; wr_n = 1'b0;
        idle(3);
        sel_n = 1'b1; wr_n = 1'b1; data = 8'h0F;
        idle(5);
        pulse_load();
        expect_codes(12'hC99, 12'h7AB, "R8 data sampled during strobe");

        // R7: load and write end in the same cycle
        @(negedge clk);
        load_n = 1'b0;
        addr = 2'b11; data = 8'h01; sel_n = 1'b0; wr_n = 1'b0;
        idle(3);
        load_n = 1'b1; sel_n = 1'b1; wr_n = 1'b1;
        idle(5);
        expect_codes(12'hC99, 12'h1AB, "R7 load released with write captures new data");

        // R7: load held low across a whole write
        @(negedge clk);
        load_n = 1'b0;
        idle(1);
        bus_write(2'b10, 8'h5E, 1, 1);
        expect_codes(12'hC99, 12'h15E, "R7 R5 write during low load tracked");
        bus_write(2'b00, 8'h55, 1, 1);
        expect_codes(12'hC55, 12'h15E, "R5 output follows while load low");
        load_n = 1'b1;
        idle(5);
        bus_write(2'b00, 8'h66, 1, 1);
        expect_codes(12'hC55, 12'h15E, "R5 R4 value held after rising load");

        pulse_load();
        expect_codes(12'hC66, 12'h15E, "R6 plain load after held write");

        // R1: reset again, staging must be cleared too
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);
        expect_codes(12'h000, 12'h000, "R1 outputs after second reset");
        pulse_load();
        expect_codes(12'h000, 12'h000, "R1 staging cleared by reset");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

endmodule